// File: doc/BRIEF.md
# Programmable Command-to-Data Latency Pipeline

This block times the data phase of a double-rate memory device model. Each read or write command strobe drops a token into a delay line. When the token has aged by the programmed latency, the block raises an enable for the data path. The enable stays up for four clocks, which carries one burst of eight beats on the double-rate bus. Read latency is the sum of two programmed parts: a column-access latency and an additive latency. Write latency is always one clock less than read latency.

A mode-load strobe sets the latencies. A load is taken only while no command is outstanding. A load that arrives while any read or write window is pending or active, or in the same cycle as a command, is refused and latches an error flag. Field values outside the legal range are clamped to the nearest legal value, and an invalid-setting flag records that this happened. The command strobes and the mode-load strobe are plain one-cycle pulses with no back-pressure. The block always accepts a command, and every command gets its own window.

Top module: `lat_pipe_top`

## Requirements
- R1: While reset is asserted and after it is released, `rd_data_en`, `wr_data_en`, `cfg_reject_err` and `cfg_invalid` are 0, and the active setting is column latency 3 with additive latency 0 (read latency 3).
- R2: A read command sampled at rising edge k raises `rd_data_en` after edge k+RL, where RL = column latency + additive latency. Before that point the read command produces no enable.
- R3: A write command sampled at rising edge k raises `wr_data_en` after edge k+RL-1.
- R4: Each command's enable lasts exactly 4 clocks, which is 8 data beats.
- R5: Commands of one kind issued every 4 clocks each keep their own window. The enable stays high without a gap for 4 clocks per command. No window is lost or merged away.
- R6: `mode_cl` carries the column latency directly as a 3-bit clock count. The values 3, 4 and 5 are legal. A value below 3 is taken as 3 and a value above 5 is taken as 5.
- R7: `mode_al` carries the additive latency directly as a 3-bit clock count. The values 0 to 4 are legal, and any value above 4 is taken as 4.
- R8: An accepted load sets `cfg_invalid` to 1 if either field needed clamping, and clears it to 0 otherwise.
- R9: A load strobed while any command's window has not yet ended, or together with a command, is ignored. The setting stays the same, and `cfg_reject_err` is set and stays set until reset.
- R10: Read and write tokens travel independently. A read and a write issued in the same cycle each produce their own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | One-cycle read command strobe |
| wr_cmd | input | 1 | One-cycle write command strobe |
| mode_load | input | 1 | One-cycle mode-load strobe |
| mode_cl | input | 3 | Column latency in clocks |
| mode_al | input | 3 | Additive latency in clocks |
| rd_data_en | output | 1 | Read data window enable |
| wr_data_en | output | 1 | Write data capture window enable |
| cfg_reject_err | output | 1 | Sticky flag: a load was refused |
| cfg_invalid | output | 1 | Last accepted load held a reserved field value |

## Verification
The bench targets the extreme latencies: a read latency of 3, and a read latency of 9 with the write window at 8. An off-by-one in the delay-line tap, or write latency tied to a fixed value, shifts the window by a clock. Reserved field codes on both sides of the legal range are loaded. A design that masks bits instead of clamping lands on the wrong latency. Back-to-back commands four clocks apart must give one unbroken enable whose length equals four clocks times the number of commands, so a design that drops or merges tokens comes up short. A load issued during a pending read must leave the latency unchanged and set a flag that only reset clears.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int FIELD_W   = 3;
  localparam int LAT_W     = 4;
  localparam int CL_MIN    = 3;
  localparam int CL_MAX    = 5;
  localparam int AL_MAX    = 4;
  localparam int BURST_CLK = 4;
  localparam int RL_MAX    = CL_MAX + AL_MAX;
  localparam int LINE_DEPTH = RL_MAX + BURST_CLK;
endpackage

// File: rtl/lat_mode_reg.sv
module lat_mode_reg #(
  parameter int FIELD_W = lat_pkg::FIELD_W,
  parameter int CL_MIN  = lat_pkg::CL_MIN,
  parameter int CL_MAX  = lat_pkg::CL_MAX,
  parameter int AL_MAX  = lat_pkg::AL_MAX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] cl_in,
  input  logic [FIELD_W-1:0] al_in,
  input  logic               busy,
  output logic [FIELD_W-1:0] cl_q,
  output logic [FIELD_W-1:0] al_q,
  output logic               invalid_q,
  output logic               reject_q
);
  localparam logic [FIELD_W-1:0] CL_LO = FIELD_W'(CL_MIN);
  localparam logic [FIELD_W-1:0] CL_HI = FIELD_W'(CL_MAX);
  localparam logic [FIELD_W-1:0] AL_HI = FIELD_W'(AL_MAX);

  logic [FIELD_W-1:0] cl_fix, al_fix;
  logic               bad;

  always_comb begin
    cl_fix = cl_in;
    if (cl_in < CL_LO) cl_fix = CL_LO;
    else if (cl_in > CL_HI) cl_fix = CL_HI;
    al_fix = (al_in > AL_HI) ? AL_HI : al_in;
    bad    = (cl_in < CL_LO) || (cl_in > CL_HI) || (al_in > AL_HI);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_q      <= CL_LO;
      al_q      <= '0;
      invalid_q <= 1'b0;
      reject_q  <= 1'b0;
    end else if (load) begin
      if (busy) begin
        reject_q <= 1'b1;
      end else begin
        cl_q      <= cl_fix;
        al_q      <= al_fix;
        invalid_q <= bad;
      end
    end
  end
endmodule

// File: rtl/lat_token_line.sv
module lat_token_line #(
  parameter int DEPTH = lat_pkg::LINE_DEPTH,
  parameter int LAT_W = lat_pkg::LAT_W,
  parameter int WIN   = lat_pkg::BURST_CLK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LAT_W-1:0] lat,
  output logic             win_en,
  output logic             live
);
  logic [DEPTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else        stage <= {stage[DEPTH-2:0], push};
  end

  always_comb begin
    win_en = 1'b0;
    live   = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (stage[j] && (j >= int'(lat)) && (j < int'(lat) + WIN)) win_en = 1'b1;
      if (stage[j] && (j < int'(lat) + WIN)) live = 1'b1;
    end
  end
endmodule

// File: rtl/lat_pipe_top.sv
module lat_pipe_top #(
  parameter int FIELD_W = lat_pkg::FIELD_W,
  parameter int LAT_W   = lat_pkg::LAT_W,
  parameter int DEPTH   = lat_pkg::LINE_DEPTH,
  parameter int WIN     = lat_pkg::BURST_CLK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_cmd,
  input  logic               wr_cmd,
  input  logic               mode_load,
  input  logic [FIELD_W-1:0] mode_cl,
  input  logic [FIELD_W-1:0] mode_al,
  output logic               rd_data_en,
  output logic               wr_data_en,
  output logic               cfg_reject_err,
  output logic               cfg_invalid
);
  logic [FIELD_W-1:0] cl_q, al_q;
  logic [LAT_W-1:0]   rd_lat, wr_lat;
  logic               rd_live, wr_live, busy;

  assign rd_lat = LAT_W'(cl_q) + LAT_W'(al_q);
  assign wr_lat = rd_lat - LAT_W'(1);
  assign busy   = rd_live | wr_live | rd_cmd | wr_cmd;

  lat_mode_reg #(.FIELD_W(FIELD_W)) i_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .cl_in(mode_cl), .al_in(mode_al),
    .busy(busy), .cl_q(cl_q), .al_q(al_q), .invalid_q(cfg_invalid),
    .reject_q(cfg_reject_err)
  );

  lat_token_line #(.DEPTH(DEPTH), .LAT_W(LAT_W), .WIN(WIN)) i_rd_line (
    .clk(clk), .rst_n(rst_n), .push(rd_cmd), .lat(rd_lat),
    .win_en(rd_data_en), .live(rd_live)
  );

  lat_token_line #(.DEPTH(DEPTH), .LAT_W(LAT_W), .WIN(WIN)) i_wr_line (
    .clk(clk), .rst_n(rst_n), .push(wr_cmd), .lat(wr_lat),
    .win_en(wr_data_en), .live(wr_live)
  );
endmodule

// File: rtl/lat_pipe_chk.sv
module lat_pipe_chk #(
  parameter int FIELD_W = lat_pkg::FIELD_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_cmd,
  input logic               wr_cmd,
  input logic               mode_load,
  input logic               busy,
  input logic               rd_live,
  input logic               wr_live,
  input logic               rd_data_en,
  input logic               wr_data_en,
  input logic               cfg_reject_err,
  input logic [FIELD_W-1:0] cl_q,
  input logic [FIELD_W-1:0] al_q
);
  p_cl_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q >= FIELD_W'(lat_pkg::CL_MIN)) && (cl_q <= FIELD_W'(lat_pkg::CL_MAX)));

  p_al_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    al_q <= FIELD_W'(lat_pkg::AL_MAX));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && busy) |=> ($stable(cl_q) && $stable(al_q)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject_err |=> cfg_reject_err);

  p_rd_not_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !rd_live) |=> !rd_data_en ##1 !rd_data_en ##1 !rd_data_en);

  p_wr_not_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !wr_live) |=> !wr_data_en ##1 !wr_data_en);

  p_rd_win_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data_en) |=> rd_data_en ##1 rd_data_en ##1 rd_data_en);

  p_wr_win_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_data_en) |=> wr_data_en ##1 wr_data_en ##1 wr_data_en);
endmodule

bind lat_pipe_top lat_pipe_chk #(.FIELD_W(FIELD_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .mode_load(mode_load),
  .busy(busy), .rd_live(rd_live), .wr_live(wr_live), .rd_data_en(rd_data_en),
  .wr_data_en(wr_data_en), .cfg_reject_err(cfg_reject_err), .cl_q(cl_q), .al_q(al_q)
);

// File: tb/test_lat_pipe_top.sv
module test_lat_pipe_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_cmd = 1'b0, wr_cmd = 1'b0, mode_load = 1'b0;
  logic [2:0] mode_cl = 3'd3, mode_al = 3'd0;
  logic       rd_data_en, wr_data_en, cfg_reject_err, cfg_invalid;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lat_pipe_top i_lat_pipe_top (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .mode_load(mode_load),
    .mode_cl(mode_cl), .mode_al(mode_al), .rd_data_en(rd_data_en),
    .wr_data_en(wr_data_en), .cfg_reject_err(cfg_reject_err), .cfg_invalid(cfg_invalid)
  );

  localparam int NV = 8;
  localparam int V_CL [NV] = '{3, 4, 5, 4, 7, 2, 5, 0};
  localparam int V_AL [NV] = '{0, 1, 4, 3, 0, 3, 6, 7};
  localparam int V_RL [NV] = '{3, 5, 9, 7, 5, 6, 9, 7};
  localparam int V_INV[NV] = '{0, 0, 0, 0, 1, 1, 1, 1};

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_mode(input int cl, input int al);
    @(negedge clk);
    mode_cl = 3'(cl);
    mode_al = 3'(al);
    mode_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  // Cycle c drives masks bit c; sample after edge c expects token from cycle k at age c-k.
  task automatic run_seq(input logic [31:0] rmask, input logic [31:0] wmask,
                         input logic [31:0] mmask, input int rl, input string req);
    for (int c = 0; c < 28; c++) begin
      int er, ew;
      rd_cmd = rmask[c];
      wr_cmd = wmask[c];
      mode_load = mmask[c];
      @(posedge clk);
      @(negedge clk);
      rd_cmd = 1'b0;
      wr_cmd = 1'b0;
      mode_load = 1'b0;
      er = 0;
      ew = 0;
      for (int k = 0; k <= c; k++) begin
        if (rmask[k] && (c - k >= rl) && (c - k <= rl + 3)) er = 1;
        if (wmask[k] && (c - k >= rl - 1) && (c - k <= rl + 2)) ew = 1;
      end
      check(req, int'(rd_data_en), er, $sformatf("rd_data_en cycle %0d rl %0d", c, rl));
      check(req, int'(wr_data_en), ew, $sformatf("wr_data_en cycle %0d wl %0d", c, rl - 1));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state and default latency 3
    check("R1", int'(rd_data_en), 0, "rd_data_en after reset");
    check("R1", int'(wr_data_en), 0, "wr_data_en after reset");
    check("R1", int'(cfg_reject_err), 0, "cfg_reject_err after reset");
    check("R1", int'(cfg_invalid), 0, "cfg_invalid after reset");
    run_seq(32'h1, 32'h1, 32'h0, 3, "R1");

    // R2 R3 R4 R6 R7 R8 R10: vector table of mode settings
    for (int v = 0; v < NV; v++) begin
      load_mode(V_CL[v], V_AL[v]);
      check("R8", int'(cfg_invalid), V_INV[v], $sformatf("cfg_invalid vector %0d", v));
      run_seq(32'h1, 32'h1, 32'h0, V_RL[v], "R2/R3/R6/R7");
    end

    // R5: back-to-back commands every 4 clocks at read latency 5
    load_mode(4, 1);
    run_seq(32'h111, 32'h444, 32'h0, 5, "R5");
    // R10: read and write staggered and together
    run_seq(32'h3001, 32'h1001, 32'h0, 5, "R10");

    // R9: load during a pending read is refused
    load_mode(3, 0);
    check("R9", int'(cfg_reject_err), 0, "cfg_reject_err before busy load");
    mode_cl = 3'd5;
    mode_al = 3'd4;
    run_seq(32'h1, 32'h0, 32'h2, 3, "R9");
    check("R9", int'(cfg_reject_err), 1, "cfg_reject_err after busy load");
    run_seq(32'h1, 32'h1, 32'h0, 3, "R9");
    // R9: load together with a command is refused
    run_seq(32'h1, 32'h0, 32'h1, 3, "R9");
    load_mode(4, 0);
    check("R9", int'(cfg_reject_err), 1, "cfg_reject_err stays set");
    check("R8", int'(cfg_invalid), 0, "cfg_invalid legal load");
    run_seq(32'h1, 32'h1, 32'h0, 4, "R9");

    // R1: reset clears the flag and restores latency 3
    load_mode(7, 7);
    check("R8", int'(cfg_invalid), 1, "cfg_invalid reserved load");
    do_reset();
    check("R1", int'(cfg_reject_err), 0, "cfg_reject_err after second reset");
    check("R1", int'(cfg_invalid), 0, "cfg_invalid after second reset");
    run_seq(32'h1, 32'h1, 32'h0, 3, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule